// File: doc/BRIEF.md
# Deep-Sleep Watchdog Timer

This block is a watchdog meant to keep running while the rest of the chip is in deep sleep. It counts ticks from one of two slow reference clocks. The two references are an internal RC oscillator and a secondary crystal oscillator. Each reaches the block as a one-cycle enable pulse in the system clock domain. When the programmed interval has passed, the block raises a single-cycle timeout pulse. Power-management logic uses that pulse as a wake or reset event.

The count is split into two stages. A fixed divide-by-32 prescale gives a base unit of roughly one millisecond from a reference near 32 kHz. A postscale stage then multiplies that unit by a power of two, chosen by a 5-bit code. Software firmware can kick the counter back to zero at any time. Leaving deep sleep, disabling the watchdog, or changing the clock choice or the interval also throws away any partial count.

Top module: `dsWdt`

## Requirements
- R1: After reset the timeout output is low and the internal count is zero. With the watchdog armed, the first timeout needs the full programmed number of reference ticks.
- R2: With postscale code 0, the timeout comes after exactly 32 selected reference ticks.
- R3: Postscale code n gives a timeout after exactly 2^(n+5) selected reference ticks. The counter is wide enough for code 31, which is 2^36 ticks.
- R4: When clkSel is 1, only refRcTick advances the count. When clkSel is 0, only refOscTick advances it. Pulses on the reference that is not selected have no effect.
- R5: The counter runs only while wdtEnable and deepSleep are both 1. If either one is 0, the count stays at zero and no timeout is produced.
- R6: If either wdtEnable or deepSleep drops to 0 for even one cycle, any partial count is discarded.
- R7: A kick pulse sets the count to zero. A kick wins over a selected tick in the same cycle, so that cycle neither advances the count nor produces a timeout.
- R8: timeoutPulse goes high for exactly one cycle, in the cycle after the clock edge that sampled the terminal tick. The count then restarts from zero, and the next timeout again needs the full interval.
- R9: If clkSel or postCode differs from its value in the previous cycle, the count restarts at zero. A tick in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refRcTick | input | 1 | One-cycle tick from the internal RC reference |
| refOscTick | input | 1 | One-cycle tick from the secondary oscillator reference |
| clkSel | input | 1 | Reference select: 1 picks the RC tick, 0 picks the oscillator tick |
| wdtEnable | input | 1 | Watchdog enable |
| deepSleep | input | 1 | High while the system is in deep sleep |
| kick | input | 1 | Strobe that clears the count |
| postCode | input | 5 | Postscale code; the interval is 2^(postCode+5) ticks |
| timeoutPulse | output | 1 | One-cycle timeout event |

## Verification
The count itself cannot be seen at the ports. A wrong count therefore shows up only as a timeout pulse that arrives too early, too late, or not at all. Because of this, every cycle is compared with a tick-accurate model, so an off-by-one in the terminal compare appears exactly one tick away from the expected pulse. A missed clear is caught by the next pulse, which then arrives short of the full interval after a kick, a sleep exit or a setting change. A wide interval with code 10 confirms that the upper counter bits carry correctly.

// File: rtl/dsWdtPkg.sv
package dsWdtPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // force count to zero
    logic incCnt;   // advance count by one
  } cntCmd_t;
endpackage

// File: rtl/dsWdtDatapath.sv
module dsWdtDatapath
  import dsWdtPkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int PRE_LOG2  = 5,
  localparam int CNT_W    = PRE_LOG2 + (1 << CODE_W) - 1,
  localparam int SHIFT_W  = $clog2(CNT_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic [CODE_W-1:0] postCode,
  output logic              atTerm
);
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   lastVal;
  logic [SHIFT_W-1:0] shiftAmt;

  // Terminal value is 2^(code+prescale) - 1
  always_comb begin
    shiftAmt = SHIFT_W'(postCode) + SHIFT_W'(PRE_LOG2);
    if (int'(shiftAmt) >= CNT_W)
      lastVal = '1;
    else
      lastVal = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
  end

  assign atTerm = (cntQ == lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (cmd.clrCnt)  cntQ <= '0;
    else if (cmd.incCnt)  cntQ <= cntQ + CNT_W'(1);
  end
endmodule

// File: rtl/dsWdtCtrl.sv
module dsWdtCtrl
  import dsWdtPkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refRcTick,
  input  logic              refOscTick,
  input  logic              clkSel,
  input  logic              wdtEnable,
  input  logic              deepSleep,
  input  logic              kick,
  input  logic [CODE_W-1:0] postCode,
  input  logic              atTerm,
  output cntCmd_t           cmd,
  output logic              timeoutPulse
);
  logic              prevSel;
  logic [CODE_W-1:0] prevCode;
  logic              selTick;
  logic              running;
  logic              cfgChange;
  logic              restart;
  logic              fire;
  logic              timeoutQ;

  always_comb begin
    selTick   = clkSel ? refRcTick : refOscTick;
    running   = wdtEnable && deepSleep;
    cfgChange = (clkSel != prevSel) || (postCode != prevCode);
    restart   = !running || kick || cfgChange;
    fire      = !restart && selTick && atTerm;
    cmd.clrCnt = restart || fire;
    cmd.incCnt = !restart && selTick && !atTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel  <= 1'b0;
      prevCode <= '0;
      timeoutQ <= 1'b0;
    end else begin
      prevSel  <= clkSel;
      prevCode <= postCode;
      timeoutQ <= fire;
    end
  end

  assign timeoutPulse = timeoutQ;
endmodule

// File: rtl/dsWdt.sv
module dsWdt
  import dsWdtPkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int PRE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refRcTick,
  input  logic              refOscTick,
  input  logic              clkSel,
  input  logic              wdtEnable,
  input  logic              deepSleep,
  input  logic              kick,
  input  logic [CODE_W-1:0] postCode,
  output logic              timeoutPulse
);
  cntCmd_t cmd;
  logic    atTerm;

  dsWdtCtrl #(.CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .refRcTick(refRcTick), .refOscTick(refOscTick),
    .clkSel(clkSel), .wdtEnable(wdtEnable), .deepSleep(deepSleep),
    .kick(kick), .postCode(postCode), .atTerm(atTerm), .cmd(cmd),
    .timeoutPulse(timeoutPulse)
  );

  dsWdtDatapath #(.CODE_W(CODE_W), .PRE_LOG2(PRE_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .postCode(postCode), .atTerm(atTerm)
  );
endmodule

// File: rtl/dsWdtChecker.sv
module dsWdtChecker #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              refRcTick,
  input logic              refOscTick,
  input logic              clkSel,
  input logic              wdtEnable,
  input logic              deepSleep,
  input logic              kick,
  input logic [CODE_W-1:0] postCode,
  input logic              timeoutPulse
);
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!wdtEnable || !deepSleep) |=> !timeoutPulse);

  a_r7_kick_blocks: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !timeoutPulse);

  a_r9_sel_change: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel != $past(clkSel)) |=> !timeoutPulse);

  a_r9_code_change: assert property (@(posedge clk) disable iff (!rstN)
    (postCode != $past(postCode)) |=> !timeoutPulse);

  a_r4_needs_sel_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!(clkSel ? refRcTick : refOscTick)) |=> !timeoutPulse);
endmodule

bind dsWdt dsWdtChecker #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .refRcTick(refRcTick), .refOscTick(refOscTick),
  .clkSel(clkSel), .wdtEnable(wdtEnable), .deepSleep(deepSleep),
  .kick(kick), .postCode(postCode), .timeoutPulse(timeoutPulse)
);

// File: tb/dsWdt_tb.sv
module dsWdt_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refRcTick = 1'b0, refOscTick = 1'b0, clkSel = 1'b0;
  logic       wdtEnable = 1'b0, deepSleep = 1'b0, kick = 1'b0;
  logic [4:0] postCode = '0;
  logic       timeoutPulse;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // reference model state
  longint mCnt = 0;
  bit     mPrevSel = 1'b0;
  logic [4:0] mPrevCode = '0;
  bit     expTo = 1'b0;

  always #5 clk = ~clk;

  dsWdt dut_i (
    .clk(clk), .rstN(rstN), .refRcTick(refRcTick), .refOscTick(refOscTick),
    .clkSel(clkSel), .wdtEnable(wdtEnable), .deepSleep(deepSleep),
    .kick(kick), .postCode(postCode), .timeoutPulse(timeoutPulse)
  );

  function automatic longint termTicks(input logic [4:0] code);
    return longint'(1) << (int'(code) + 5);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: timeoutPulse actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Predict from current inputs, advance one clock, compare at negedge
  task automatic step(input string tag);
    bit tick, restart;
    tick    = clkSel ? refRcTick : refOscTick;
    restart = !(wdtEnable && deepSleep) || kick ||
              (clkSel != mPrevSel) || (postCode != mPrevCode);
    expTo = 1'b0;
    if (restart) mCnt = 0;
    else if (tick) begin
      if (mCnt == termTicks(postCode) - 1) begin mCnt = 0; expTo = 1'b1; end
      else mCnt++;
    end
    mPrevSel  = clkSel;
    mPrevCode = postCode;
    @(posedge clk);
    @(negedge clk);
    chk(tag, timeoutPulse, expTo);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      refRcTick = clkSel; refOscTick = !clkSel;
      step(tag);
    end
    refRcTick = 1'b0; refOscTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20245));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset", timeoutPulse, 1'b0);

    // R1/R2: code 0, RC reference, first interval is full 32 ticks
    wdtEnable = 1; deepSleep = 1; clkSel = 1; postCode = 0;
    step("R9 settle");
    ticks(31, "R1");
    ticks(1,  "R2");
    ticks(40, "R2 R8");

    // R3: code 1 and code 10
    postCode = 1; step("R9");
    ticks(130, "R3");
    postCode = 10; step("R9");
    ticks(32770, "R3 wide");

    // R4: only the unselected reference ticks
    postCode = 0; step("R9");
    for (int i = 0; i < 40; i++) begin refOscTick = 1; step("R4"); end
    refOscTick = 0;
    clkSel = 0; step("R9");
    for (int i = 0; i < 40; i++) begin refRcTick = 1; step("R4"); end
    refRcTick = 0;
    ticks(33, "R4 osc");

    // R5: gated off
    wdtEnable = 0; ticks(40, "R5 en");
    wdtEnable = 1; deepSleep = 0; ticks(40, "R5 ds");
    deepSleep = 1;

    // R6: partial count discarded by a one-cycle exit
    ticks(20, "R6");
    deepSleep = 0; step("R6"); deepSleep = 1;
    ticks(31, "R6"); ticks(2, "R6");
    ticks(20, "R6");
    wdtEnable = 0; step("R6"); wdtEnable = 1;
    ticks(33, "R6");

    // R7: kick mid-count and kick with terminal tick
    ticks(25, "R7");
    kick = 1; step("R7"); kick = 0;
    ticks(31, "R7");
    kick = 1; refOscTick = 1; step("R7 prio"); kick = 0; refOscTick = 0;
    ticks(33, "R7");

    // R9: change code, change select mid-count
    ticks(20, "R9");
    postCode = 1; refOscTick = 1; step("R9 code"); refOscTick = 0;
    postCode = 0; step("R9 code");
    ticks(33, "R9");
    ticks(20, "R9");
    clkSel = 1; step("R9 sel");
    ticks(33, "R9");

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      refRcTick  = ($urandom % 3) != 0;
      refOscTick = ($urandom % 2) != 0;
      kick       = ($urandom % 500) == 0;
      if (($urandom % 2000) == 0) clkSel = ~clkSel;
      if (($urandom % 3000) == 0) postCode = 5'($urandom % 3);
      deepSleep  = ($urandom % 1500) != 0;
      wdtEnable  = ($urandom % 2500) != 0;
      step("R8 random");
    end

    done = 1'b1;
    finishRun();
  end
endmodule